// File: doc/BRIEF.md
# Block-Transposing Bulk Transfer Engine

This engine moves blocks of 64-bit words from a local memory read port to a streaming register bank write port without help from a compute thread. It can reshape the data while it moves it. A single descriptor sets up a transfer. The descriptor holds a source address, a destination address, a word count, a stride, a layout mode and a byte-lane selector. After a fixed setup, the engine issues one source read per cycle and produces destination words in the order the mode sets.

The engine has six layouts:
- a plain row copy;
- gathering the rows of a square (pitched) region into a linear block;
- scattering a linear block into a pitched region;
- extracting one byte column from strided words;
- transposing 8x8 byte tiles through an internal buffer;
- packing the low halves of word pairs.

A one-cycle pulse marks the end of a transfer. A descriptor that cannot be taken produces an error pulse and changes nothing.

Top module: `blk_xfer_engine`

## Requirements
- R1: After reset, busy, errPulse, donePulse, rdEn and wrEn are all low.
- R2: A descriptor is accepted on a clock edge where cmdValid is high and the engine is idle. busy is high from the next cycle. That cycle is a setup cycle with no read. The first read, at the source address, is issued in the cycle after it.
- R3: Mode 0 (row copy): destination word j at cmdDst+j takes source word cmdSrc+j. The cmdLen writes come on consecutive cycles. The first write appears three cycles after the acceptance edge.
- R4: Mode 1 (square to linear): destination word j at cmdDst+j takes source word cmdSrc+j*cmdStride.
- R5: Mode 2 (linear to square): destination word j is written at cmdDst+j*cmdStride and takes source word cmdSrc+j.
- R6: Mode 3 (column): the engine reads 8*cmdLen words at cmdSrc+k*cmdStride. Destination word j at cmdDst+j holds, in byte r (bits 8r+7..8r), byte lane cmdLane of read 8j+r.
- R7: Mode 4 (transpose): tile t is made of rows cmdSrc+(8t+r)*cmdStride, r=0..7. Destination word 8t+c at cmdDst+8t+c holds, in byte r, byte c of row r. Reads stop while a tile drains. The first write appears eleven cycles after the acceptance edge.
- R8: Mode 5 (pack): destination word j at cmdDst+j is {high 32 bits = low half of source cmdSrc+2j+1, low 32 bits = low half of source cmdSrc+2j}.
- R9: donePulse is high for exactly one cycle, the cycle after the last destination write. busy is low in that same cycle.
- R10: A descriptor presented while busy is rejected. errPulse is high in the next cycle, and the running transfer writes exactly what it would have written without it.
- R11: The engine rejects a descriptor with mode 6 or 7, with cmdLen of 0, or in mode 4 with cmdLen not a multiple of 8. It raises errPulse in the next cycle, stays idle and issues no read.
- R12: rdEn and wrEn are high only while busy. A transfer issues exactly cmdLen reads in modes 0, 1, 2 and 4, 8*cmdLen in mode 3, and 2*cmdLen in mode 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Descriptor present this cycle |
| cmdMode | input | 3 | Layout mode, 0..5 valid |
| cmdSrc | input | 16 | Source start word address |
| cmdDst | input | 16 | Destination start word address |
| cmdStride | input | 16 | Stride in words for strided sides |
| cmdLen | input | 8 | Destination word count |
| cmdLane | input | 3 | Byte lane taken in column mode |
| busy | output | 1 | Transfer in progress |
| errPulse | output | 1 | Descriptor rejected (one cycle) |
| donePulse | output | 1 | Transfer finished (one cycle) |
| rdEn | output | 1 | Source read request |
| rdAddr | output | 16 | Source read address |
| rdData | input | 64 | Source data, valid the cycle after rdEn |
| wrEn | output | 1 | Destination write strobe |
| wrAddr | output | 16 | Destination write address |
| wrData | output | 64 | Destination write data |

## Verification
The assertions take three things for granted about the inputs:
- the source port returns data exactly one cycle after each read request, with no stall;
- cmdValid is low during reset;
- address sums may wrap at 16 bits.

The bench memory model always answers with a fixed one-cycle registered read. Random descriptors draw only lengths and strides that keep every address in a small window. The invalid-length and invalid-mode cases are sent only through directed rejection cases, which check that the engine stays idle.

// File: rtl/bxf_pkg.sv
`timescale 1ns/1ps
package bxf_pkg;
  typedef enum logic [2:0] {
    M_ROW       = 3'd0,
    M_SQ2LIN    = 3'd1,
    M_LIN2SQ    = 3'd2,
    M_COLUMN    = 3'd3,
    M_TRANSPOSE = 3'd4,
    M_PACK      = 3'd5
  } xferMode_e;

  typedef struct packed {
    logic load;
    logic issue;
  } ctlStrobe_t;
endpackage

// File: rtl/bxf_ctrl.sv
`timescale 1ns/1ps
module bxf_ctrl import bxf_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int TILE   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdMode,
  input  logic [ADDR_W-1:0] cmdSrc,
  input  logic [ADDR_W-1:0] cmdStride,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic              wrFire,
  output ctlStrobe_t        strb,
  output logic              busy,
  output logic              errPulse,
  output logic              donePulse,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr
);
  localparam int LOG_T  = $clog2(TILE);
  localparam int TILE_W = LOG_T + 1;
  localparam int CNT_W  = LEN_W + LOG_T + 1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_RUN} state_e;

  state_e            state;
  xferMode_e         modeR;
  logic [ADDR_W-1:0] srcPtr, srcStep;
  logic [CNT_W-1:0]  rdLeft;
  logic [LEN_W-1:0]  wrLeft;
  logic [TILE_W-1:0] tileReads;
  logic              errR, doneR;

  logic modeOk, lenOk, accept, issue, tileEnd, lastWr;
  logic [CNT_W-1:0]  readTotal;
  logic [ADDR_W-1:0] stepSel;

  always_comb begin
    modeOk = (cmdMode <= 3'd5);
    lenOk  = (cmdLen != '0) &&
             !((cmdMode == M_TRANSPOSE) && (cmdLen[LOG_T-1:0] != '0));
    accept = cmdValid && (state == S_IDLE) && modeOk && lenOk;
    case (cmdMode)
      M_COLUMN: readTotal = CNT_W'(cmdLen) << LOG_T;
      M_PACK:   readTotal = CNT_W'(cmdLen) << 1;
      default:  readTotal = CNT_W'(cmdLen);
    endcase
    stepSel = (cmdMode == M_SQ2LIN || cmdMode == M_COLUMN || cmdMode == M_TRANSPOSE)
              ? cmdStride : ADDR_W'(1);
    issue   = (state == S_RUN) && (rdLeft != '0) &&
              !((modeR == M_TRANSPOSE) && (tileReads == TILE_W'(TILE)));
    tileEnd = wrFire && (modeR == M_TRANSPOSE) && (wrLeft[LOG_T-1:0] == LOG_T'(1));
    lastWr  = wrFire && (wrLeft == LEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      modeR     <= M_ROW;
      srcPtr    <= '0;
      srcStep   <= '0;
      rdLeft    <= '0;
      wrLeft    <= '0;
      tileReads <= '0;
      errR      <= 1'b0;
      doneR     <= 1'b0;
    end else begin
      errR  <= cmdValid && !accept;
      doneR <= lastWr;
      case (state)
        S_IDLE:  if (accept) begin
                   state     <= S_SETUP;
                   modeR     <= xferMode_e'(cmdMode);
                   srcPtr    <= cmdSrc;
                   srcStep   <= stepSel;
                   rdLeft    <= readTotal;
                   wrLeft    <= cmdLen;
                   tileReads <= '0;
                 end
        S_SETUP: state <= S_RUN;
        default: if (lastWr) state <= S_IDLE;
      endcase
      if (issue) begin
        srcPtr <= srcPtr + srcStep;
        rdLeft <= rdLeft - CNT_W'(1);
        if (modeR == M_TRANSPOSE) tileReads <= tileReads + TILE_W'(1);
      end
      if (tileEnd) tileReads <= '0;
      if (wrFire)  wrLeft <= wrLeft - LEN_W'(1);
    end
  end

  assign strb.load  = accept;
  assign strb.issue = issue;
  assign busy       = (state != S_IDLE);
  assign errPulse   = errR;
  assign donePulse  = doneR;
  assign rdEn       = issue;
  assign rdAddr     = srcPtr;
endmodule

// File: rtl/bxf_datapath.sv
`timescale 1ns/1ps
module bxf_datapath import bxf_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int ELEM_W = 8,
  localparam int TILE   = DATA_W / ELEM_W,
  localparam int LANE_W = $clog2(TILE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [2:0]        cmdMode,
  input  logic [ADDR_W-1:0] cmdDst,
  input  logic [ADDR_W-1:0] cmdStride,
  input  logic [LANE_W-1:0] cmdLane,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  localparam int HALF = DATA_W / 2;

  xferMode_e         modeR;
  logic [ADDR_W-1:0] dstPtr, dstStep;
  logic [LANE_W-1:0] lane, recvCnt, drainIdx;
  logic              rdValid, draining;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] tile [TILE];
  logic [DATA_W-1:0] colWord, emitData;
  logic [ELEM_W-1:0] laneElem;
  logic              emitNow, lastOfGroup;

  for (genvar r = 0; r < TILE; r++) begin : g_col
    assign colWord[r*ELEM_W +: ELEM_W] = tile[r][drainIdx*ELEM_W +: ELEM_W];
  end

  always_comb begin
    laneElem    = rdData[lane*ELEM_W +: ELEM_W];
    lastOfGroup = (recvCnt == LANE_W'(TILE-1));
    emitNow     = 1'b0;
    emitData    = rdData;
    if (rdValid) begin
      case (modeR)
        M_COLUMN:    begin emitNow = lastOfGroup; emitData = {laneElem, acc[DATA_W-1:ELEM_W]}; end
        M_PACK:      begin emitNow = recvCnt[0];  emitData = {rdData[HALF-1:0], acc[DATA_W-1:HALF]}; end
        M_TRANSPOSE: emitNow = 1'b0;
        default:     emitNow = 1'b1;
      endcase
    end
    if (draining) begin
      emitNow  = 1'b1;
      emitData = colWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeR    <= M_ROW;
      dstPtr   <= '0;
      dstStep  <= '0;
      lane     <= '0;
      recvCnt  <= '0;
      drainIdx <= '0;
      rdValid  <= 1'b0;
      draining <= 1'b0;
      acc      <= '0;
      wrEn     <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      rdValid <= strb.issue;
      wrEn    <= emitNow;
      if (strb.load) begin
        modeR    <= xferMode_e'(cmdMode);
        dstPtr   <= cmdDst;
        dstStep  <= (cmdMode == M_LIN2SQ) ? cmdStride : ADDR_W'(1);
        lane     <= cmdLane;
        recvCnt  <= '0;
        draining <= 1'b0;
      end else begin
        if (rdValid) begin
          recvCnt <= recvCnt + LANE_W'(1);
          if (modeR == M_COLUMN) acc <= {laneElem, acc[DATA_W-1:ELEM_W]};
          if (modeR == M_PACK)   acc <= {rdData[HALF-1:0], acc[DATA_W-1:HALF]};
          if (modeR == M_TRANSPOSE && lastOfGroup) begin
            draining <= 1'b1;
            drainIdx <= '0;
          end
        end
        if (draining) begin
          drainIdx <= drainIdx + LANE_W'(1);
          if (drainIdx == LANE_W'(TILE-1)) draining <= 1'b0;
        end
        if (emitNow) begin
          wrAddr <= dstPtr;
          wrData <= emitData;
          dstPtr <= dstPtr + dstStep;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rdValid && modeR == M_TRANSPOSE) tile[recvCnt] <= rdData;
  end
endmodule

// File: rtl/blk_xfer_engine.sv
`timescale 1ns/1ps
module blk_xfer_engine import bxf_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 64,
  parameter int ELEM_W = 8,
  localparam int TILE   = DATA_W / ELEM_W,
  localparam int LANE_W = $clog2(TILE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdMode,
  input  logic [ADDR_W-1:0] cmdSrc,
  input  logic [ADDR_W-1:0] cmdDst,
  input  logic [ADDR_W-1:0] cmdStride,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [LANE_W-1:0] cmdLane,
  output logic              busy,
  output logic              errPulse,
  output logic              donePulse,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  ctlStrobe_t strb;

  bxf_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TILE(TILE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdMode(cmdMode),
    .cmdSrc(cmdSrc), .cmdStride(cmdStride), .cmdLen(cmdLen), .wrFire(wrEn),
    .strb(strb), .busy(busy), .errPulse(errPulse), .donePulse(donePulse),
    .rdEn(rdEn), .rdAddr(rdAddr)
  );

  bxf_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ELEM_W(ELEM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdMode(cmdMode), .cmdDst(cmdDst),
    .cmdStride(cmdStride), .cmdLane(cmdLane), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: rtl/bxf_checker.sv
`timescale 1ns/1ps
module bxf_checker (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic busy,
  input logic errPulse,
  input logic donePulse,
  input logic rdEn,
  input logic wrEn
);
  // R12
  a_r12_read_needs_busy: assert property (@(posedge clk) disable iff (!rstN) rdEn |-> busy);
  a_r12_write_needs_busy: assert property (@(posedge clk) disable iff (!rstN) wrEn |-> busy);
  // R9
  a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rstN) donePulse |-> $past(wrEn));
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rstN) donePulse |-> !busy);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN) donePulse |=> !donePulse);
  // R2
  a_r2_setup_no_read: assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |-> !rdEn);
  a_r2_first_read: assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |=> rdEn);
  // R10
  a_r10_err_from_cmd: assert property (@(posedge clk) disable iff (!rstN) errPulse |-> $past(cmdValid));
  // R11
  a_r11_err_no_start: assert property (@(posedge clk) disable iff (!rstN) errPulse |-> !$rose(busy));
endmodule

bind blk_xfer_engine bxf_checker u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .busy(busy), .errPulse(errPulse),
  .donePulse(donePulse), .rdEn(rdEn), .wrEn(wrEn)
);

// File: tb/blk_xfer_engine_test.sv
`timescale 1ns/1ps
module blk_xfer_engine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdMode = '0;
  logic [15:0] cmdSrc = '0, cmdDst = '0, cmdStride = '0;
  logic [7:0]  cmdLen = '0;
  logic [2:0]  cmdLane = '0;
  logic        busy, errPulse, donePulse, rdEn, wrEn;
  logic [15:0] rdAddr, wrAddr;
  logic [63:0] rdData = '0, wrData;

  int checks = 0, fails = 0, cyc = 0;
  int nWr, nRd, firstWrCyc, lastWrCyc, doneCyc;
  bit doneBusy;
  logic [63:0] mem  [1024];
  logic [15:0] logA [256];
  logic [63:0] logD [256];

  blk_xfer_engine uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdMode(cmdMode), .cmdSrc(cmdSrc),
    .cmdDst(cmdDst), .cmdStride(cmdStride), .cmdLen(cmdLen), .cmdLane(cmdLane),
    .busy(busy), .errPulse(errPulse), .donePulse(donePulse), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) rdData <= mem[rdAddr[9:0]];

  always @(negedge clk) begin
    if (rstN) begin
      if (wrEn) begin
        if (nWr < 256) begin logA[nWr] = wrAddr; logD[nWr] = wrData; end
        if (nWr == 0) firstWrCyc = cyc;
        lastWrCyc = cyc;
        nWr++;
      end
      if (rdEn) nRd++;
      if (donePulse) begin doneCyc = cyc; doneBusy = busy; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input int mode);
    case (mode)
      0: return "R3"; 1: return "R4"; 2: return "R5";
      3: return "R6"; 4: return "R7"; default: return "R8";
    endcase
  endfunction

  function automatic logic [63:0] expData(input int mode, src, stride, lane, j);
    logic [63:0] w = '0;
    int t = j / 8, c = j % 8;
    case (mode)
      0, 2: w = mem[(src + j) % 1024];
      1:    w = mem[(src + j * stride) % 1024];
      3: for (int r = 0; r < 8; r++) w[8*r +: 8] = mem[(src + (8*j + r) * stride) % 1024][8*lane +: 8];
      4: for (int r = 0; r < 8; r++) w[8*r +: 8] = mem[(src + (8*t + r) * stride) % 1024][8*c +: 8];
      default: w = {mem[(src + 2*j + 1) % 1024][31:0], mem[(src + 2*j) % 1024][31:0]};
    endcase
    return w;
  endfunction

  function automatic logic [15:0] expAddr(input int mode, dst, stride, j);
    return (mode == 2) ? 16'(dst + j * stride) : 16'(dst + j);
  endfunction

  task automatic runXfer(input int mode, src, dst, len, stride, lane,
                         input bit timing, input bit inject);
    int acc, guard, reads, badJ;
    logic [63:0] ed; logic [15:0] ea;
    string rq;
    rq = reqOf(mode);
    @(negedge clk);
    nWr = 0; nRd = 0; firstWrCyc = -1; lastWrCyc = -1; doneCyc = -1; doneBusy = 0;
    cmdValid = 1; cmdMode = 3'(mode); cmdSrc = 16'(src); cmdDst = 16'(dst);
    cmdStride = 16'(stride); cmdLen = 8'(len); cmdLane = 3'(lane);
    @(negedge clk);
    cmdValid = 0;
    acc = cyc;
    chk(busy && !rdEn, "R2", "busy set, no read in setup", {busy, rdEn}, 2'b10);
    @(negedge clk);
    chk(rdEn && rdAddr == 16'(src), "R2", "first read address", rdAddr, src);
    if (inject) begin
      @(negedge clk);
      cmdValid = 1; cmdMode = 3'd3; cmdSrc = 16'd7; cmdDst = 16'd900; cmdLen = 8'd2;
      @(negedge clk);
      cmdValid = 0;
      chk(errPulse && busy, "R10", "reject while busy", {errPulse, busy}, 2'b11);
    end
    guard = 0;
    while (doneCyc < 0 && guard < 5000) begin @(posedge clk); guard++; end
    @(negedge clk); @(negedge clk);
    chk(doneCyc >= 0, "R9", "done seen", doneCyc, 1);
    chk(nWr == len, rq, "write count", nWr, len);
    reads = (mode == 3) ? 8 * len : (mode == 5) ? 2 * len : len;
    chk(nRd == reads, "R12", "read count", nRd, reads);
    badJ = -1;
    for (int j = 0; j < len && j < 256; j++) begin
      ed = expData(mode, src, stride, lane, j);
      ea = expAddr(mode, dst, stride, j);
      if (badJ < 0 && (logD[j] !== ed || logA[j] !== ea)) badJ = j;
    end
    if (badJ >= 0)
      chk(0, rq, $sformatf("word %0d data/addr", badJ), {logA[badJ][7:0], logD[badJ][55:0]},
          {expAddr(mode, dst, stride, badJ)[7:0], expData(mode, src, stride, lane, badJ)[55:0]});
    else chk(1, rq, "words", 0, 0);
    chk(doneCyc == lastWrCyc + 1 && !doneBusy, "R9", "done timing", doneCyc - lastWrCyc, 1);
    if (timing) begin
      if (mode == 0) begin
        chk(firstWrCyc - acc == 3, "R3", "first write latency", firstWrCyc - acc, 3);
        chk(lastWrCyc - firstWrCyc == len - 1, "R3", "back-to-back writes", lastWrCyc - firstWrCyc, len - 1);
      end
      if (mode == 4)
        chk(firstWrCyc - acc == 11, "R7", "first write latency", firstWrCyc - acc, 11);
    end
  endtask

  task automatic rejectIdle(input int mode, len, input string what);
    @(negedge clk);
    nRd = 0;
    cmdValid = 1; cmdMode = 3'(mode); cmdLen = 8'(len); cmdSrc = 16'd3; cmdStride = 16'd1;
    @(negedge clk);
    cmdValid = 0;
    chk(errPulse && !busy, "R11", what, {errPulse, busy}, 2'b10);
    repeat (4) @(negedge clk);
    chk(!busy && !errPulse, "R11", {what, " stays idle"}, {busy, errPulse}, 0);
    @(posedge clk);
    chk(nRd == 0, "R11", {what, " no reads"}, nRd, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0B1F));
    for (int i = 0; i < 1024; i++) mem[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    chk({busy, errPulse, donePulse, rdEn, wrEn} == 0, "R1", "reset outputs",
        {busy, errPulse, donePulse, rdEn, wrEn}, 0);
    rstN = 1;
    @(negedge clk);
    chk({busy, errPulse, donePulse, rdEn, wrEn} == 0, "R1", "idle after reset",
        {busy, errPulse, donePulse, rdEn, wrEn}, 0);

    runXfer(0, 10, 100, 16, 1, 0, 1, 0);   // R3
    runXfer(1, 40, 200, 8, 5, 0, 0, 0);    // R4
    runXfer(2, 90, 300, 6, 4, 0, 0, 0);    // R5
    runXfer(3, 20, 400, 3, 3, 5, 0, 0);    // R6
    runXfer(3, 0, 410, 1, 1, 7, 0, 0);     // R6 top lane
    runXfer(4, 60, 500, 16, 2, 0, 1, 0);   // R7
    runXfer(5, 130, 600, 5, 1, 0, 0, 0);   // R8
    runXfer(0, 5, 700, 16, 1, 0, 0, 1);    // R10
    rejectIdle(6, 4, "mode 6");            // R11
    rejectIdle(7, 4, "mode 7");
    rejectIdle(0, 0, "zero length");
    rejectIdle(4, 4, "transpose partial tile");

    for (int k = 0; k < 10; k++) begin
      int m, l;
      m = $urandom_range(0, 5);
      l = (m == 4) ? 8 * $urandom_range(1, 2) : $urandom_range(1, 12);
      runXfer(m, $urandom_range(0, 100), $urandom_range(0, 300), l,
              $urandom_range(1, 9), $urandom_range(0, 7), 0, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule